// File: doc/BRIEF.md
# Stacked-Strip Coincidence Readout Logic

This block is the digital back end of a detector module built from two stacked strip sensors. The upper sensor has 64 long strips and the lower sensor has 320 short strips. Each long strip sits above five consecutive short strips. When a capture strobe arrives, the block registers the discriminated hit bits of both layers. At the same edge it marks a coincidence for every long strip whose own hit lines up with a hit on any of its five short strips.

After the capture the block offers three summary flags: any upper hit, any lower hit and any coincidence. It then streams the captured pattern out on four serial lanes, each covering a quarter of the long strips. Every long strip gets an 8-bit group on its lane. A test selector replaces the live hit inputs of both layers with a preloaded pattern, so the whole path can be exercised without a sensor.

Readout control is a two-state machine. ST_IDLE waits for a strobe. The transition "accept" (strobe seen in ST_IDLE) captures the hits, loads the lane shifters and enters ST_SHIFT. ST_SHIFT holds itself through "advance" for each bit. The transition "finish", taken on the last bit, returns it to ST_IDLE.

Top module: `strip_coinc_readout`

## Requirements
- R1: After reset, busy, frame_valid, all lane_data bits and the three fast-OR outputs are 0.
- R2: The coincidence bit of long strip i is 1 exactly when top hit i is set and at least one of bottom hits 5i to 5i+4 is set.
- R3: Each strip's 8-bit group goes out first bit first in this order: top hit, coincidence, bottom hits 5i, 5i+1, 5i+2, 5i+3, 5i+4, then a spare bit that is always 0.
- R4: Lane k (k = 0..3) carries long strips 16k to 16k+15 in ascending order, so each lane sends 128 bits per event.
- R5: frame_valid is high for exactly 128 consecutive cycles. It starts the cycle after an accepted strobe, and lane_data is 0 whenever frame_valid is low.
- R6: busy is high for the whole readout. A strobe that arrives while busy is high changes neither the stream in progress nor the fast-OR outputs.
- R7: The fast-OR outputs (any top hit, any bottom hit, any coincidence) reflect the captured event from the cycle after the accepted strobe until the next accepted strobe. Input changes between strobes have no effect on them.
- R8: When test_en is 1 at an accepted strobe, the test_top/test_bot pattern is captured instead of the live inputs, for both layers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Capture request for one bunch crossing |
| test_en | input | 1 | Selects the test pattern instead of the live hits |
| hit_top | input | 64 | Live long-strip hits, upper sensor |
| hit_bot | input | 320 | Live short-strip hits, lower sensor |
| test_top | input | 64 | Injected upper-layer pattern |
| test_bot | input | 320 | Injected lower-layer pattern |
| busy | output | 1 | Readout in progress |
| frame_valid | output | 1 | lane_data carries event bits |
| lane_data | output | 4 | Serial lane outputs, one bit per lane |
| fast_or_top | output | 1 | Any captured top hit |
| fast_or_bot | output | 1 | Any captured bottom hit |
| fast_or_coinc | output | 1 | Any captured coincidence |

## Verification
The strobe is registered at one edge, call it E0. The fast-OR outputs, busy, frame_valid and bit 0 of every lane are due right after E0. Bit n of a lane is due right after edge En, and frame_valid drops after edge E128. The bench raises the strobe half a cycle before E0 and reads every result half a cycle after the edge that produces it. One sample is taken per bit, so an off-by-one shift in the stream or the valid window shows up as a mismatch. The ignored-strobe test pulses a second strobe mid-stream with different inputs. It then keeps comparing the rest of the stream and the fast-OR outputs against the first event.

// File: rtl/scr_pkg.sv
package scr_pkg;
    // readout control states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1
    } rd_state_e;
endpackage

// File: rtl/scr_capture.sv
module scr_capture #(
    parameter int N_LONG = 64,
    parameter int FAN    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  test_en,
    input  logic [N_LONG-1:0]     live_top,
    input  logic [N_LONG*FAN-1:0] live_bot,
    input  logic [N_LONG-1:0]     test_top,
    input  logic [N_LONG*FAN-1:0] test_bot,
    output logic [N_LONG-1:0]     sel_top,
    output logic [N_LONG*FAN-1:0] sel_bot,
    output logic [N_LONG-1:0]     sel_coinc,
    output logic [N_LONG-1:0]     lat_top,
    output logic [N_LONG*FAN-1:0] lat_bot,
    output logic [N_LONG-1:0]     lat_coinc
);
    // source select: injected pattern or live discriminator bits
    assign sel_top = test_en ? test_top : live_top;
    assign sel_bot = test_en ? test_bot : live_bot;

    // per-strip coincidence against the OR of the strips beneath
    for (genvar g = 0; g < N_LONG; g++) begin : g_coinc
        assign sel_coinc[g] = sel_top[g] & (|sel_bot[g*FAN +: FAN]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_top   <= '0;
            lat_bot   <= '0;
            lat_coinc <= '0;
        end else if (load) begin
            lat_top   <= sel_top;
            lat_bot   <= sel_bot;
            lat_coinc <= sel_coinc;
        end
    end
endmodule

// File: rtl/scr_fastor.sv
module scr_fastor #(
    parameter int N_LONG = 64,
    parameter int FAN    = 5
) (
    input  logic [N_LONG-1:0]     lat_top,
    input  logic [N_LONG*FAN-1:0] lat_bot,
    input  logic [N_LONG-1:0]     lat_coinc,
    output logic                  any_top,
    output logic                  any_bot,
    output logic                  any_coinc
);
    logic [N_LONG-1:0] group_or;

    // bottom summary built from one small OR per long strip
    for (genvar g = 0; g < N_LONG; g++) begin : g_grp
        assign group_or[g] = |lat_bot[g*FAN +: FAN];
    end

    assign any_top   = |lat_top;
    assign any_bot   = |group_or;
    assign any_coinc = |lat_coinc;
endmodule

// File: rtl/scr_serializer.sv
module scr_serializer
    import scr_pkg::*;
#(
    parameter int N_LONG  = 64,
    parameter int FAN     = 5,
    parameter int N_LANES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strobe,
    input  logic [N_LONG-1:0]     sel_top,
    input  logic [N_LONG*FAN-1:0] sel_bot,
    input  logic [N_LONG-1:0]     sel_coinc,
    output logic                  accept,
    output logic                  busy,
    output logic                  frame_valid,
    output logic [N_LANES-1:0]    lane_data
);
    localparam int FRAME_BITS = FAN + 3;
    localparam int PER_LANE   = N_LONG / N_LANES;
    localparam int LANE_BITS  = PER_LANE * FRAME_BITS;
    localparam int CNT_W      = $clog2(LANE_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(LANE_BITS - 1);

    rd_state_e          state_q, state_d;
    logic [CNT_W-1:0]   bit_q;
    logic               last_bit;
    logic [LANE_BITS-1:0] shreg_q [N_LANES];
    logic [LANE_BITS-1:0] frame_img [N_LANES];

    assign last_bit = (bit_q == LAST_BIT);

    // frame image per lane: first transmitted bit sits at the MSB
    for (genvar k = 0; k < N_LANES; k++) begin : g_img
        for (genvar s = 0; s < PER_LANE; s++) begin : g_strip
            localparam int STRIP = k * PER_LANE + s;
            localparam int TOPB  = LANE_BITS - 1 - s * FRAME_BITS;
            assign frame_img[k][TOPB]                = sel_top[STRIP];
            assign frame_img[k][TOPB-1]              = sel_coinc[STRIP];
            for (genvar p = 0; p < FAN; p++) begin : g_bot
                assign frame_img[k][TOPB-2-p]        = sel_bot[STRIP*FAN + p];
            end
            assign frame_img[k][TOPB-FRAME_BITS+1]   = 1'b0;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe) begin
                    accept  = 1'b1;
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (last_bit) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept || state_q != ST_SHIFT) bit_q <= '0;
            else                              bit_q <= bit_q + 1'b1;
        end
    end

    // lane shifters
    for (genvar k = 0; k < N_LANES; k++) begin : g_shift
        always_ff @(posedge clk) begin
            if (!rst_n)                   shreg_q[k] <= '0;
            else if (accept)              shreg_q[k] <= frame_img[k];
            else if (state_q == ST_SHIFT) shreg_q[k] <= {shreg_q[k][LANE_BITS-2:0], 1'b0};
        end
    end

    // outputs
    always_comb begin
        busy        = (state_q == ST_SHIFT);
        frame_valid = (state_q == ST_SHIFT);
        for (int k = 0; k < N_LANES; k++) begin
            lane_data[k] = frame_valid & shreg_q[k][LANE_BITS-1];
        end
    end
endmodule

// File: rtl/strip_coinc_readout.sv
module strip_coinc_readout #(
    parameter int N_LONG  = 64,
    parameter int FAN     = 5,
    parameter int N_LANES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strobe,
    input  logic                  test_en,
    input  logic [N_LONG-1:0]     hit_top,
    input  logic [N_LONG*FAN-1:0] hit_bot,
    input  logic [N_LONG-1:0]     test_top,
    input  logic [N_LONG*FAN-1:0] test_bot,
    output logic                  busy,
    output logic                  frame_valid,
    output logic [N_LANES-1:0]    lane_data,
    output logic                  fast_or_top,
    output logic                  fast_or_bot,
    output logic                  fast_or_coinc
);
    localparam int N_SHORT = N_LONG * FAN;

    logic                accept;
    logic [N_LONG-1:0]   sel_top, sel_coinc, lat_top, lat_coinc;
    logic [N_SHORT-1:0]  sel_bot, lat_bot;

    scr_capture #(.N_LONG(N_LONG), .FAN(FAN)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .test_en  (test_en),
        .live_top (hit_top),
        .live_bot (hit_bot),
        .test_top (test_top),
        .test_bot (test_bot),
        .sel_top  (sel_top),
        .sel_bot  (sel_bot),
        .sel_coinc(sel_coinc),
        .lat_top  (lat_top),
        .lat_bot  (lat_bot),
        .lat_coinc(lat_coinc)
    );

    scr_fastor #(.N_LONG(N_LONG), .FAN(FAN)) u_fastor (
        .lat_top  (lat_top),
        .lat_bot  (lat_bot),
        .lat_coinc(lat_coinc),
        .any_top  (fast_or_top),
        .any_bot  (fast_or_bot),
        .any_coinc(fast_or_coinc)
    );

    scr_serializer #(.N_LONG(N_LONG), .FAN(FAN), .N_LANES(N_LANES)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .sel_top    (sel_top),
        .sel_bot    (sel_bot),
        .sel_coinc  (sel_coinc),
        .accept     (accept),
        .busy       (busy),
        .frame_valid(frame_valid),
        .lane_data  (lane_data)
    );
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
    parameter int N_LONG  = 64,
    parameter int FAN     = 5,
    parameter int N_LANES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               strobe,
    input logic               busy,
    input logic               frame_valid,
    input logic [N_LANES-1:0] lane_data,
    input logic               fast_or_top,
    input logic               fast_or_bot,
    input logic               fast_or_coinc
);
    localparam int LANE_BITS = (N_LONG / N_LANES) * (FAN + 3);
    localparam int CW        = $clog2(LANE_BITS + 1);

    logic [CW-1:0] vcnt;
    always_ff @(posedge clk) begin
        if (!rst_n)           vcnt <= '0;
        else if (frame_valid) vcnt <= vcnt + 1'b1;
        else                  vcnt <= '0;
    end

    assert_quiet_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> lane_data == '0);

    assert_window_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_valid && vcnt != '0) |-> vcnt == CW'(LANE_BITS));

    assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> vcnt < CW'(LANE_BITS));

    assert_start_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_valid) |-> $past(strobe));

    assert_busy_covers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> busy);

    assert_hold_fastor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && vcnt != '0) |-> $stable({fast_or_top, fast_or_bot, fast_or_coinc}));

    assert_spare_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && vcnt[2:0] == 3'd7) |-> lane_data == '0);

    assert_coinc_implies_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fast_or_coinc |-> (fast_or_top && fast_or_bot));
endmodule

bind strip_coinc_readout scr_checker #(.N_LONG(N_LONG), .FAN(FAN), .N_LANES(N_LANES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .busy         (busy),
    .frame_valid  (frame_valid),
    .lane_data    (lane_data),
    .fast_or_top  (fast_or_top),
    .fast_or_bot  (fast_or_bot),
    .fast_or_coinc(fast_or_coinc)
);

// File: tb/strip_coinc_readout_bench.sv
`timescale 1ns/1ps
module strip_coinc_readout_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         strobe = 1'b0;
    logic         test_en = 1'b0;
    logic [63:0]  hit_top = '0;
    logic [319:0] hit_bot = '0;
    logic [63:0]  test_top = '0;
    logic [319:0] test_bot = '0;
    logic         busy, frame_valid, fast_or_top, fast_or_bot, fast_or_coinc;
    logic [3:0]   lane_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    strip_coinc_readout u_strip_coinc_readout (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .test_en(test_en),
        .hit_top(hit_top), .hit_bot(hit_bot), .test_top(test_top), .test_bot(test_bot),
        .busy(busy), .frame_valid(frame_valid), .lane_data(lane_data),
        .fast_or_top(fast_or_top), .fast_or_bot(fast_or_bot), .fast_or_coinc(fast_or_coinc)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit coinc_of(input logic [63:0] t, input logic [319:0] b, input int s);
        return t[s] && (b[5*s] || b[5*s+1] || b[5*s+2] || b[5*s+3] || b[5*s+4]);
    endfunction

    // expected bit n of lane k
    function automatic bit exp_bit(input logic [63:0] t, input logic [319:0] b,
                                   input int k, input int n);
        int s = 16*k + n/8;
        int p = n % 8;
        if (p == 0) return t[s];
        if (p == 1) return coinc_of(t, b, s);
        if (p == 7) return 1'b0;
        return b[5*s + p - 2];
    endfunction

    // one event: capture, check fast-ORs, check all 128 bits on each lane.
    // inject_at >= 0 pulses a second strobe with different inputs mid-stream.
    task automatic run_event(input logic [63:0] t, input logic [319:0] b,
                             input bit use_test, input int inject_at, input string req);
        bit et = |t;
        bit eb = |b;
        bit ec = 1'b0;
        int mism = 0;
        int vbad = 0;
        logic [3:0] first_act = '0, first_exp = '0;
        for (int s = 0; s < 64; s++) if (coinc_of(t, b, s)) ec = 1'b1;
        @(negedge clk);
        test_en = use_test;
        if (use_test) begin
            test_top = t; test_bot = b; hit_top = ~t; hit_bot = ~b;
        end else begin
            hit_top = t; hit_bot = b; test_top = ~t; test_bot = ~b;
        end
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        check(busy === 1'b1, "R6", "busy after strobe", 64'(busy), 64'd1);
        check({fast_or_top, fast_or_bot, fast_or_coinc} === {et, eb, ec},
              "R7", "fast-OR {top,bot,coinc}", 64'({fast_or_top, fast_or_bot, fast_or_coinc}),
              64'({et, eb, ec}));
        for (int n = 0; n < 128; n++) begin
            logic [3:0] e;
            if (n > 0) @(negedge clk);
            if (n == inject_at + 1) strobe = 1'b0;
            for (int k = 0; k < 4; k++) e[k] = exp_bit(t, b, k, n);
            if (frame_valid !== 1'b1) vbad++;
            if (lane_data !== e) begin
                if (mism == 0) begin first_act = lane_data; first_exp = e; end
                mism++;
            end
            if (n == inject_at) begin
                strobe = 1'b1; hit_top = '1; hit_bot = '1; test_top = '1; test_bot = '1;
                test_en = ~use_test;
            end
        end
        strobe = 1'b0;
        check(mism == 0, req, "lane stream (first bad lane nibble)", 64'(first_act), 64'(first_exp));
        check(vbad == 0, "R5", "frame_valid low cycles inside window", 64'(vbad), 64'd0);
        @(negedge clk);
        check(frame_valid === 1'b0 && lane_data === 4'b0, "R5", "window end {valid,lanes}",
              64'({frame_valid, lane_data}), 64'd0);
        check(busy === 1'b0, "R6", "busy after readout", 64'(busy), 64'd0);
        check({fast_or_top, fast_or_bot, fast_or_coinc} === {et, eb, ec},
              "R7", "fast-OR held after readout", 64'({fast_or_top, fast_or_bot, fast_or_coinc}),
              64'({et, eb, ec}));
        // live inputs change without a strobe: nothing may move (R7)
        hit_top = ~hit_top; hit_bot = ~hit_bot; test_en = 1'b0;
        @(negedge clk);
        check({fast_or_top, fast_or_bot, fast_or_coinc, frame_valid} === {et, eb, ec, 1'b0},
              "R7", "outputs with no strobe", 64'({fast_or_top, fast_or_bot, fast_or_coinc, frame_valid}),
              64'({et, eb, ec, 1'b0}));
    endtask

    task automatic test_reset();
        check({busy, frame_valid, lane_data, fast_or_top, fast_or_bot, fast_or_coinc} === '0,
              "R1", "reset outputs",
              64'({busy, frame_valid, lane_data, fast_or_top, fast_or_bot, fast_or_coinc}), 64'd0);
    endtask

    task automatic test_single_coinc();
        logic [319:0] b = '0;
        b[2] = 1'b1;
        run_event(64'd1, b, 1'b0, -1, "R2 R3 single coincidence strip 0");
    endtask

    task automatic test_top_and_bottom_apart();
        logic [63:0]  t = '0;
        logic [319:0] b = '0;
        t[17] = 1'b1;
        b[202] = 1'b1;   // under strip 40
        b[89]  = 1'b1;   // strip 17 owns 85..89: coincidence at the group edge
        b[90]  = 1'b1;   // strip 18, no top hit
        run_event(t, b, 1'b0, -1, "R2 group edge");
        t = '0; t[17] = 1'b1;
        b = '0; b[90] = 1'b1; b[84] = 1'b1;
        run_event(t, b, 1'b0, -1, "R2 neighbour hits only, no coincidence");
    endtask

    task automatic test_lane_edges();
        logic [63:0]  t = '0;
        logic [319:0] b = '0;
        t[15] = 1'b1; t[16] = 1'b1; t[48] = 1'b1; t[63] = 1'b1;
        b[79] = 1'b1; b[80] = 1'b1; b[244] = 1'b1; b[319] = 1'b1;
        run_event(t, b, 1'b0, -1, "R4 lane boundary strips");
    endtask

    task automatic test_full_and_empty();
        run_event('1, '1, 1'b0, -1, "R3 all hits");
        run_event('0, '0, 1'b0, -1, "R2 empty event");
    endtask

    task automatic test_random();
        for (int r = 0; r < 3; r++) begin
            logic [63:0]  t;
            logic [319:0] b;
            t = {$urandom, $urandom} & {$urandom, $urandom};
            for (int w = 0; w < 10; w++) b[32*w +: 32] = $urandom & $urandom & $urandom;
            run_event(t, b, 1'b0, -1, "R4 mixed pattern");
        end
    endtask

    task automatic test_injection();
        logic [319:0] b = '0;
        b[7] = 1'b1; b[300] = 1'b1;
        run_event(64'h8000_0000_0000_0002, b, 1'b1, -1, "R8 test pattern");
    endtask

    task automatic test_ignored_strobe();
        logic [319:0] b = '0;
        b[3] = 1'b1;
        run_event(64'h0000_0000_0000_0001, b, 1'b0, 40, "R6 strobe during readout");
    endtask

    task automatic test_back_to_back();
        logic [319:0] b = '0;
        b[159] = 1'b1;
        run_event(64'h0000_0000_8000_0000, b, 1'b0, -1, "R5 first of pair");
        run_event(64'h0000_0001_0000_0000, '0, 1'b0, -1, "R5 second of pair");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_single_coinc();
        test_top_and_bottom_apart();
        test_lane_edges();
        test_full_and_empty();
        test_random();
        test_injection();
        test_ignored_strobe();
        test_back_to_back();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule